// File: doc/BRIEF.md
# Sliced Sixteen-Bit Two's-Complement ALU

This block is a purely combinational arithmetic and logic unit for two 16-bit two's-complement operands. A 3-bit operation select picks one of eight functions. These are three arithmetic operations (sum, difference and increment of the first operand), three bitwise logical operations (AND, OR, XNOR) and two pass-throughs. The block drives a 16-bit result and two status flags. One flag marks a negative result. The other marks a result that is all zeros. Both flags are valid for every operation, including the logical ones.

The datapath is a chain of identical 4-bit slice modules. Each slice receives the operation, its nibble of both operands and a carry from the slice below, and it hands its carry to the slice above. A small decoder at the top converts the select code into the chain's initial carry. A flag unit reads the assembled result. Arithmetic wraps modulo 2^16. Overflow and the final carry are not reported. The block can be placed inside any registered datapath, because it holds no state.

Top module: `alu16`

## Requirements
- R1: With op_sel = 3'b000 the result is (a + b) mod 2^16.
- R2: With op_sel = 3'b001 the result is (a - b) mod 2^16, formed as a + ~b + 1; for example 7 - 8 gives 16'hFFFF.
- R3: With op_sel = 3'b010 the result is (a + 1) mod 2^16 and b has no effect; a = 16'hFFFF gives 0 with zero set.
- R4: With op_sel = 3'b011 the result is the bitwise AND of a and b.
- R5: With op_sel = 3'b100 the result is the bitwise OR of a and b.
- R6: With op_sel = 3'b101 the result is the bitwise XNOR of a and b; for example 5 and 4 give 16'hFFFE.
- R7: With op_sel = 3'b110 the result equals a and b has no effect.
- R8: With op_sel = 3'b111 the result equals b and a has no effect.
- R9: neg equals bit 15 of the result for every operation.
- R10: zero is 1 exactly when all 16 result bits are 0, for every operation.
- R11: Carries cross every 4-bit slice boundary; for example 16'h0FFF + 1 gives 16'h1000 and 16'hFFFF + 1 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation select code |
| a | input | 16 | First operand, two's complement, bit 15 most significant |
| b | input | 16 | Second operand, two's complement |
| c | output | 16 | Result |
| neg | output | 1 | Result is negative |
| zero | output | 1 | Result is all zeros |

## Verification
The bound checker holds all the time. It compares sum, increment, AND and both pass-throughs against the operands. It checks that neg follows the sign of the operand passed through for the pass-A operation and that zero follows the emptiness of b for the pass-B operation. Only the bench's scenarios can show that the difference, OR and XNOR operations are correct, that carries cross each slice boundary, and that both flags are right after every operation. The bench does this with directed corner vectors and random operands, checked against a behavioural reference.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
   typedef enum logic [2:0] {
      OP_ADD   = 3'b000,
      OP_SUB   = 3'b001,
      OP_INC   = 3'b010,
      OP_AND   = 3'b011,
      OP_OR    = 3'b100,
      OP_XNOR  = 3'b101,
      OP_PASSA = 3'b110,
      OP_PASSB = 3'b111
   } op_e;

   localparam int OP_W = 3;
endpackage

// File: rtl/alu16_opdec.sv
module alu16_opdec
   import alu16_pkg::*;
(
   input  logic [OP_W-1:0] op_sel,
   output op_e             op,
   output logic            chain_cin
);
   always_comb begin
      op        = op_e'(op_sel);
      chain_cin = (op == OP_SUB) || (op == OP_INC);
   end
endmodule

// File: rtl/alu16_slice.sv
module alu16_slice
   import alu16_pkg::*;
#(
   parameter int W      = 4,
   parameter bit RIPPLE = 1'b0
)(
   input  op_e          op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] r,
   output logic         cout
);
   logic [W-1:0] b_arith;
   logic [W-1:0] sum;

   always_comb begin
      unique case (op)
         OP_SUB:  b_arith = ~b;
         OP_INC:  b_arith = '0;
         default: b_arith = b;
      endcase
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] cc;
      always_comb begin
         cc[0] = cin;
         for (int i = 0; i < W; i++) begin
            sum[i]  = a[i] ^ b_arith[i] ^ cc[i];
            cc[i+1] = (a[i] & b_arith[i]) | (cc[i] & (a[i] ^ b_arith[i]));
         end
      end
      assign cout = cc[W];
   end else begin : g_operator
      logic [W:0] wide;
      assign wide = {1'b0, a} + {1'b0, b_arith} + {{W{1'b0}}, cin};
      assign sum  = wide[W-1:0];
      assign cout = wide[W];
   end

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB, OP_INC: r = sum;
         OP_AND:   r = a & b;
         OP_OR:    r = a | b;
         OP_XNOR:  r = ~(a ^ b);
         OP_PASSA: r = a;
         default:  r = b;
      endcase
   end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
   parameter int W = 16
)(
   input  logic [W-1:0] res,
   output logic         neg,
   output logic         zero
);
   assign neg  = res[W-1];
   assign zero = ~(|res);
endmodule

// File: rtl/alu16.sv
module alu16
   import alu16_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int SLICE_W = 4,
   parameter bit RIPPLE  = 1'b0
)(
   input  logic [2:0]  op_sel,
   input  logic [15:0] a,
   input  logic [15:0] b,
   output logic [15:0] c,
   output logic        neg,
   output logic        zero
);
   localparam int NUM_SLICES = DATA_W / SLICE_W;

   if (SLICE_W < 1) begin : g_bad_slice
      $error("alu16: SLICE_W must be at least 1");
   end
   if (DATA_W % SLICE_W != 0) begin : g_bad_split
      $error("alu16: DATA_W must be a multiple of SLICE_W");
   end
   if (DATA_W != 16) begin : g_bad_width
      $error("alu16: port width is fixed at 16 bits");
   end

   op_e                   op;
   logic                  chain_cin;
   logic [NUM_SLICES:0]   carry;
   logic [DATA_W-1:0]     res;

   alu16_opdec u_dec (
      .op_sel    (op_sel),
      .op        (op),
      .chain_cin (chain_cin)
   );

   assign carry[0] = chain_cin;

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      alu16_slice #(
         .W      (SLICE_W),
         .RIPPLE (RIPPLE)
      ) u_slice (
         .op   (op),
         .a    (a[s*SLICE_W +: SLICE_W]),
         .b    (b[s*SLICE_W +: SLICE_W]),
         .cin  (carry[s]),
         .r    (res[s*SLICE_W +: SLICE_W]),
         .cout (carry[s+1])
      );
   end

   alu16_flags #(.W(DATA_W)) u_flags (
      .res  (res),
      .neg  (neg),
      .zero (zero)
   );

   assign c = res;
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
   parameter int DATA_W = 16
)(
   input logic [2:0]        op_sel,
   input logic [DATA_W-1:0] a,
   input logic [DATA_W-1:0] b,
   input logic [DATA_W-1:0] c,
   input logic              neg,
   input logic              zero
);
   always_comb begin
      // R1
      if (op_sel == 3'b000) add_sum_chk: assert (c == DATA_W'(a + b));
      // R3
      if (op_sel == 3'b010) inc_a_chk: assert (c == DATA_W'(a + 1'b1));
      // R4
      if (op_sel == 3'b011) and_bits_chk: assert (c == (a & b));
      // R7
      if (op_sel == 3'b110) pass_a_chk: assert (c == a);
      // R8
      if (op_sel == 3'b111) pass_b_chk: assert (c == b);
      // R9
      if (op_sel == 3'b110) neg_sign_chk: assert (neg == a[DATA_W-1]);
      // R10
      if (op_sel == 3'b111) zero_flag_chk: assert (zero == (b == '0));
   end
endmodule

bind alu16 alu16_chk #(.DATA_W(DATA_W)) u_chk (
   .op_sel (op_sel),
   .a      (a),
   .b      (b),
   .c      (c),
   .neg    (neg),
   .zero   (zero)
);

// File: tb/alu16_bench.sv
module alu16_bench;
   logic        clk = 1'b0;
   logic [2:0]  op_sel = 3'b000;
   logic [15:0] a = 16'h0000;
   logic [15:0] b = 16'h0000;
   logic [15:0] c;
   logic        neg, zero;
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #2 clk = ~clk;

   alu16 u_alu16 (
      .op_sel (op_sel),
      .a      (a),
      .b      (b),
      .c      (c),
      .neg    (neg),
      .zero   (zero)
   );

   function automatic logic [15:0] model(input int op, input logic [15:0] x, input logic [15:0] y);
      int sx, sy, t;
      sx = int'($signed(x));
      sy = int'($signed(y));
      case (op)
         0: t = sx + sy;
         1: t = sx - sy;
         2: t = sx + 1;
         3: return x & y;
         4: return x | y;
         5: return ~(x ^ y);
         6: return x;
         default: return y;
      endcase
      return t[15:0];
   endfunction

   function automatic string tag_of(input int op);
      case (op)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         6: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic run(input int op, input logic [15:0] x, input logic [15:0] y, input string extra);
      logic [15:0] e;
      @(negedge clk);
      op_sel = 3'(op);
      a = x;
      b = y;
      @(posedge clk);
      #1;
      e = model(op, x, y);
      check({tag_of(op), extra}, c, e);
      check("R9 neg", {15'd0, neg}, {15'd0, e[15]});
      check("R10 zero", {15'd0, zero}, {15'd0, (e == 16'h0000)});
   endtask

   initial begin
      // reset state: all-zero inputs select an add of zeros
      @(posedge clk);
      #1;
      check("R1 idle", c, 16'h0000);
      check("R10 idle zero", {15'd0, zero}, 16'd1);
      check("R9 idle neg", {15'd0, neg}, 16'd0);

      run(0, 16'hFFFF, 16'h0002, "");
      check("R1 add -1+2", c, 16'h0001);
      run(1, 16'h0007, 16'h0008, "");
      check("R2 sub 7-8", c, 16'hFFFF);
      run(2, 16'hFFFF, 16'h000C, "");
      check("R3 inc -1", c, 16'h0000);
      run(3, 16'h0007, 16'h0005, "");
      check("R4 and", c, 16'h0005);
      run(4, 16'h0006, 16'h0005, "");
      check("R5 or", c, 16'h0007);
      run(5, 16'h0005, 16'h0004, "");
      check("R6 xnor", c, 16'hFFFE);
      run(6, 16'hFF80, 16'h0041, "");
      check("R7 passA", c, 16'hFF80);
      run(7, 16'h0005, 16'h000A, "");
      check("R8 passB", c, 16'h000A);

      // R11 carry across slice boundaries
      run(0, 16'h0FFF, 16'h0001, " R11");
      check("R11 add 0FFF+1", c, 16'h1000);
      run(0, 16'hFFFF, 16'h0001, " R11");
      check("R11 add wrap", c, 16'h0000);
      run(2, 16'h00FF, 16'h1234, " R11");
      check("R11 inc 00FF", c, 16'h0100);
      run(1, 16'h0000, 16'h0001, " R11");
      check("R11 sub 0-1", c, 16'hFFFF);
      run(1, 16'h8000, 16'h8000, "");
      // R3 / R7 / R8: ignored operand swept with the used one held
      run(2, 16'h1234, 16'hFFFF, "");
      run(6, 16'h0000, 16'hFFFF, "");
      run(7, 16'hFFFF, 16'h0000, "");
      run(5, 16'hAAAA, 16'h5555, "");

      for (int op = 0; op < 8; op++) begin
         for (int k = 0; k < 150; k++) begin
            run(op, 16'($urandom), 16'($urandom), " rnd");
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule